// File: doc/BRIEF.md
# Watchdog Timer with Gated Reset Request

This block is a watchdog peripheral built around a 32-bit down-counter. Software loads a duration into the counter register. Each later write to that register reloads it and serves as the keep-alive. While the control register's enable bit is set, the counter steps down once per tick. A tick comes either from a power-of-two prescaler on the block clock or, when the fixed-source select is set, from a strobe supplied by a fixed reference clock domain that has already been brought into the block clock domain.

When the count steps from one to zero, several things happen at once:
- a sticky expired flag in the status register is set;
- an interrupt output pulses for one cycle;
- the counter stops at zero;
- a one-cycle reset request is raised, but only if the watchdog is armed.

The watchdog is armed when three conditions hold together: the timer is enabled, the reset-output enable is set, and the reset-output mask is clear. The enable and the mask each sit in a single-register port of their own, apart from the timer's register bus. After reset the mask is set, so no reset request can leave the block until software clears it.

Top module: `wdg_timer`

## Requirements
- R1: After reset, the following read as zero: control (offset 0x00), status (offset 0x04), counter (offset 0x34), the reset-output port and the outputs `irq_pulse`, `rst_req` and `armed`. The mask port reads 0x0000_0400 (mask bit 10 set).
- R2: A write to offset 0x34 loads the counter, and reading offset 0x34 returns the remaining count. While control bit 8 (enable) is clear, the count holds. Control reads back only bit 8, bit 10 and the ratio field in bits 20:16; all other control bits, and any unmapped offset, read as zero.
- R3: With control bit 10 clear and ratio field value N, an enabled counter decrements once every 2^N clocks. The first decrement comes 2^N clocks after the control write.
- R4: With control bit 10 set, an enabled counter decrements once for each cycle in which `ref_tick` is high, and the ratio field has no effect.
- R5: When an enabled count steps from 1 to 0, the following hold on the next edge: status bit 31 is set, `irq_pulse` is high for exactly one cycle, and the counter stays at 0 from then on. A count loaded as 0 never expires.
- R6: Status bit 31 is sticky. Writing offset 0x04 with bit 31 at 0 clears it; writing it with bit 31 at 1 leaves it unchanged.
- R7: `armed` is high only when control bit 8, reset-output bit 8 and a clear mask bit 10 all hold. `rst_req` pulses for one cycle, together with `irq_pulse`, only for an expiry that happens while armed.
- R8: While mask bit 10 is set, expiry still sets the flag and pulses `irq_pulse`, but `rst_req` stays low.
- R9: Any control write restarts the prescaler and gives no tick in its own cycle. After a rewrite, the next decrement comes a full 2^N clocks later.
- R10: A counter write while the counter runs replaces the count and wins over a decrement in the same cycle. The countdown then continues from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe from the fixed reference clock, already synchronised |
| tmr_addr | input | 8 | Timer register byte offset |
| tmr_we | input | 1 | Timer register write strobe |
| tmr_wdata | input | 32 | Timer register write data |
| tmr_rdata | output | 32 | Timer register read data (combinational) |
| rso_we | input | 1 | Reset-output register write strobe |
| rso_wdata | input | 32 | Reset-output write data (bit 8 = enable) |
| rso_rdata | output | 32 | Reset-output read data |
| msk_we | input | 1 | Reset-mask register write strobe |
| msk_wdata | input | 32 | Reset-mask write data (bit 10 = mask) |
| msk_rdata | output | 32 | Reset-mask read data |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| rst_req | output | 1 | One-cycle gated reset request |
| armed | output | 1 | All three reset gating conditions hold |

## Verification
The hardest situation to reach is the prescaler restart. It only shows up when a control write arrives with the prescaler part way through a period, and a design that skips the restart differs by a single early decrement. The stimulus enables ratio 3, waits five clocks, and rewrites the same control value. It then samples the count just before the full eight-clock period ends, and again just after. Expiry is driven to each arming combination in turn: mask at its reset value, fully armed, and enable-only-cleared. The resulting reset-request pulse count shows that all three conditions gate it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int ADDR_W         = 8;
  localparam int DATA_W         = 32;
  localparam int CTRL_EN_BIT    = 8;
  localparam int CTRL_FIX_BIT   = 10;
  localparam int CTRL_RATIO_LSB = 16;
  localparam int STAT_EXP_BIT   = 31;
  localparam int RSO_EN_BIT     = 8;
  localparam int RSM_MASK_BIT   = 10;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h34;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CNT
  } wdg_sel_e;

  function automatic wdg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CTRL: decode_offset = SEL_CTRL;
      OFF_STAT: decode_offset = SEL_STAT;
      OFF_CNT:  decode_offset = SEL_CNT;
      default:  decode_offset = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int RATIO_W   = 5,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               use_fixed,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ref_tick,
  output logic               tick
);

  localparam int PRE_W = 1 << RATIO_W;

  // terminal value of the divider for a ratio exponent: 2^r - 1
  function automatic logic [PRE_W-1:0] ratio_limit(input logic [RATIO_W-1:0] r);
    ratio_limit = (PRE_W'(1) << r) - PRE_W'(1);
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic             div_hit;
  logic             src_tick;

  assign limit   = ratio_limit(ratio);
  assign div_hit = (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || !run || use_fixed) begin
      pre_q <= '0;
    end else if (div_hit) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  generate
    if (HAS_FIXED) begin : g_fixed
      assign src_tick = use_fixed ? ref_tick : div_hit;
    end else begin : g_div_only
      logic unused_fixed;
      assign unused_fixed = ref_tick ^ use_fixed;
      assign src_tick     = div_hit;
    end
  endgenerate

  assign tick = run && !restart && src_tick;

endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic dec;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    step_down = v - CNT_W'(1);
  endfunction

  assign dec    = tick && !load && (count != '0);
  assign expire = dec && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec) begin
      count <= step_down(count);
    end
  end

endmodule

// File: rtl/wdg_reset_gate.sv
module wdg_reset_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rso_we,
  input  logic rso_bit,
  input  logic msk_we,
  input  logic msk_bit,
  input  logic timer_en,
  input  logic expire,
  output logic rso_en,
  output logic mask,
  output logic armed,
  output logic irq_q,
  output logic rst_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rso_en <= 1'b0;
      mask   <= 1'b1;
    end else begin
      if (rso_we) rso_en <= rso_bit;
      if (msk_we) mask   <= msk_bit;
    end
  end

  assign armed = timer_en && rso_en && !mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= expire;
      rst_q <= expire && armed;
    end
  end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RATIO_W   = 5,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] tmr_addr,
  input  logic              tmr_we,
  input  logic [DATA_W-1:0] tmr_wdata,
  output logic [DATA_W-1:0] tmr_rdata,
  input  logic              rso_we,
  input  logic [DATA_W-1:0] rso_wdata,
  output logic [DATA_W-1:0] rso_rdata,
  input  logic              msk_we,
  input  logic [DATA_W-1:0] msk_wdata,
  output logic [DATA_W-1:0] msk_rdata,
  output logic              irq_pulse,
  output logic              rst_req,
  output logic              armed
);

  wdg_sel_e sel;

  logic               ctrl_en;
  logic               ctrl_fix;
  logic [RATIO_W-1:0] ctrl_ratio;
  logic               exp_flag;
  logic [CNT_W-1:0]   count;

  // named internal events, observed by the bound checker
  logic ctrl_wr_w;
  logic stat_clr_w;
  logic load_w;
  logic tick_w;
  logic expire_w;
  logic rso_en;
  logic mask;

  assign sel        = decode_offset(tmr_addr);
  assign ctrl_wr_w  = tmr_we && (sel == SEL_CTRL);
  assign load_w     = tmr_we && (sel == SEL_CNT);
  assign stat_clr_w = tmr_we && (sel == SEL_STAT) && !tmr_wdata[STAT_EXP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_fix   <= 1'b0;
      ctrl_ratio <= '0;
    end else if (ctrl_wr_w) begin
      ctrl_en    <= tmr_wdata[CTRL_EN_BIT];
      ctrl_fix   <= tmr_wdata[CTRL_FIX_BIT];
      ctrl_ratio <= tmr_wdata[CTRL_RATIO_LSB +: RATIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_flag <= 1'b0;
    end else if (expire_w) begin
      exp_flag <= 1'b1;
    end else if (stat_clr_w) begin
      exp_flag <= 1'b0;
    end
  end

  wdg_prescale #(
    .RATIO_W  (RATIO_W),
    .HAS_FIXED(HAS_FIXED)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_en),
    .restart  (ctrl_wr_w),
    .use_fixed(ctrl_fix),
    .ratio    (ctrl_ratio),
    .ref_tick (ref_tick),
    .tick     (tick_w)
  );

  wdg_down_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .load_val(tmr_wdata[CNT_W-1:0]),
    .tick    (tick_w),
    .count   (count),
    .expire  (expire_w)
  );

  wdg_reset_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rso_we  (rso_we),
    .rso_bit (rso_wdata[RSO_EN_BIT]),
    .msk_we  (msk_we),
    .msk_bit (msk_wdata[RSM_MASK_BIT]),
    .timer_en(ctrl_en),
    .expire  (expire_w),
    .rso_en  (rso_en),
    .mask    (mask),
    .armed   (armed),
    .irq_q   (irq_pulse),
    .rst_q   (rst_req)
  );

  always_comb begin
    tmr_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        tmr_rdata[CTRL_EN_BIT]                  = ctrl_en;
        tmr_rdata[CTRL_FIX_BIT]                 = ctrl_fix;
        tmr_rdata[CTRL_RATIO_LSB +: RATIO_W]    = ctrl_ratio;
      end
      SEL_STAT: tmr_rdata[STAT_EXP_BIT] = exp_flag;
      SEL_CNT:  tmr_rdata[CNT_W-1:0]    = count;
      default:  tmr_rdata = '0;
    endcase
  end

  always_comb begin
    rso_rdata             = '0;
    rso_rdata[RSO_EN_BIT] = rso_en;
    msk_rdata               = '0;
    msk_rdata[RSM_MASK_BIT] = mask;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{rso_wdata, msk_wdata};

endmodule

module wdg_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic             ctrl_wr_w,
  input logic             tick_w,
  input logic             load_w,
  input logic             expire_w,
  input logic             stat_clr_w,
  input logic             exp_flag,
  input logic [CNT_W-1:0] count,
  input logic             irq_pulse,
  input logic             rst_req,
  input logic             armed
);

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !load_w) |=> $stable(count));

  p_tick_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> ctrl_en);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_expiry_effects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (irq_pulse && exp_flag && count == '0));

  p_zero_rests_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load_w) |=> (count == '0));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_flag && !stat_clr_w) |=> exp_flag);

  p_rst_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (irq_pulse && $past(armed)));

  p_no_tick_on_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_w |-> !tick_w);

endmodule

bind wdg_timer wdg_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .ctrl_wr_w (ctrl_wr_w),
  .tick_w    (tick_w),
  .load_w    (load_w),
  .expire_w  (expire_w),
  .stat_clr_w(stat_clr_w),
  .exp_flag  (exp_flag),
  .count     (count),
  .irq_pulse (irq_pulse),
  .rst_req   (rst_req),
  .armed     (armed)
);

// File: tb/wdg_timer_tb.sv
module wdg_timer_tb;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h34;
  localparam logic [31:0] EN    = 32'h0000_0100;
  localparam logic [31:0] FIX   = 32'h0000_0400;

  typedef struct packed {
    logic [31:0] load;
    logic [4:0]  ratio;
    logic [15:0] waitc;
    logic [31:0] expv;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{32'd100, 5'd0, 16'd10, 32'd90},
    '{32'd100, 5'd1, 16'd10, 32'd95},
    '{32'd100, 5'd2, 16'd9,  32'd98},
    '{32'd100, 5'd3, 16'd16, 32'd98},
    '{32'd50,  5'd4, 16'd40, 32'd48},
    '{32'd7,   5'd0, 16'd5,  32'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [7:0]  tmr_addr = '0;
  logic        tmr_we = 1'b0;
  logic [31:0] tmr_wdata = '0;
  logic [31:0] tmr_rdata;
  logic        rso_we = 1'b0;
  logic [31:0] rso_wdata = '0;
  logic [31:0] rso_rdata;
  logic        msk_we = 1'b0;
  logic [31:0] msk_wdata = '0;
  logic [31:0] msk_rdata;
  logic        irq_pulse;
  logic        rst_req;
  logic        armed;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  int rst_cnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wdg_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .tmr_addr (tmr_addr),
    .tmr_we   (tmr_we),
    .tmr_wdata(tmr_wdata),
    .tmr_rdata(tmr_rdata),
    .rso_we   (rso_we),
    .rso_wdata(rso_wdata),
    .rso_rdata(rso_rdata),
    .msk_we   (msk_we),
    .msk_wdata(msk_wdata),
    .msk_rdata(msk_rdata),
    .irq_pulse(irq_pulse),
    .rst_req  (rst_req),
    .armed    (armed)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (irq_pulse) irq_cnt <= irq_cnt + 1;
    if (rst_req)   rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tmr_addr = a; tmr_wdata = d; tmr_we = 1'b1;
    @(negedge clk);
    tmr_we = 1'b0;
  endtask

  task automatic wr_rso(input logic [31:0] d);
    rso_wdata = d; rso_we = 1'b1;
    @(negedge clk);
    rso_we = 1'b0;
  endtask

  task automatic wr_msk(input logic [31:0] d);
    msk_wdata = d; msk_we = 1'b1;
    @(negedge clk);
    msk_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    tmr_addr = a;
    #1 d = tmr_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // load 3, ratio 0: count 1 after two edges, expiry on the third
  task automatic run_expiry(input string req, input logic exp_rst);
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd3);
    wr(A_CTRL, EN);
    idle(2);
    rd(A_CNT, d); chk(req, d, 32'd1);
    chk(req, {31'b0, irq_pulse}, 32'd0);
    idle(1);
    rd(A_CNT, d); chk(req, d, 32'd0);
    chk(req, {31'b0, irq_pulse}, 32'd1);
    chk(req, {31'b0, rst_req}, {31'b0, exp_rst});
    rd(A_STAT, d); chk(req, d, 32'h8000_0000);
    idle(1);
    chk(req, {31'b0, irq_pulse}, 32'd0);
    rd(A_CNT, d); chk(req, d, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int irq0;
    int rst0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 stat", d, 32'h0);
    rd(A_CNT, d);  chk("R1 cnt", d, 32'h0);
    chk("R1 rso", rso_rdata, 32'h0);
    chk("R1 mask", msk_rdata, 32'h0000_0400);
    chk("R1 outs", {29'b0, irq_pulse, rst_req, armed}, 32'h0);

    // R2 control readback and unmapped offset
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h001F_0500);
    wr(A_CTRL, 32'h0);
    rd(8'h10, d); chk("R2 unmapped", d, 32'h0);

    // R2 load and hold while disabled
    wr(A_CNT, 32'd40);
    idle(6);
    rd(A_CNT, d); chk("R2 hold", d, 32'd40);

    // R3 vector table: ratio N decrements every 2^N clocks
    foreach (VEC[i]) begin
      wr(A_CTRL, 32'h0);
      wr(A_CNT, VEC[i].load);
      wr(A_CTRL, EN | (32'(VEC[i].ratio) << 16));
      idle(int'(VEC[i].waitc));
      rd(A_CNT, d); chk("R3 ratio vector", d, VEC[i].expv);
    end

    // R2/R9 disable: no tick on the control write, then hold
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd40);
    wr(A_CTRL, EN);
    idle(4);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, d); chk("R9 no tick on ctrl write", d, 32'd36);
    idle(10);
    rd(A_CNT, d); chk("R2 hold after disable", d, 32'd36);

    // R9 prescaler restart on control rewrite
    wr(A_CNT, 32'd60);
    wr(A_CTRL, EN | (32'd3 << 16));
    idle(5);
    wr(A_CTRL, EN | (32'd3 << 16));
    idle(7);
    rd(A_CNT, d); chk("R9 restart full period", d, 32'd60);
    idle(1);
    rd(A_CNT, d); chk("R9 tick after restart", d, 32'd59);

    // R4 fixed reference source, ratio ignored
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd20);
    wr(A_CTRL, EN | FIX | (32'd5 << 16));
    for (int k = 0; k < 3; k++) begin
      idle(4);
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
    idle(4);
    rd(A_CNT, d); chk("R4 fixed ticks", d, 32'd17);

    // R10 keep-alive reload wins over decrement
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd5);
    wr(A_CTRL, EN);
    idle(3);
    rd(A_CNT, d); chk("R10 before reload", d, 32'd2);
    wr(A_CNT, 32'd10);
    rd(A_CNT, d); chk("R10 reload wins", d, 32'd10);
    idle(2);
    rd(A_CNT, d); chk("R10 continues", d, 32'd8);

    // R5 load of zero never expires
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd0);
    irq0 = irq_cnt;
    wr(A_CTRL, EN);
    idle(5);
    chk("R5 zero load no irq", 32'(irq_cnt - irq0), 32'd0);
    rd(A_STAT, d); chk("R5 zero load no flag", d, 32'h0);

    // R8 mask at reset value: irq but no reset request
    irq0 = irq_cnt; rst0 = rst_cnt;
    wr_rso(32'h0000_0100);
    chk("R8 armed low while masked", {31'b0, armed}, 32'd0);
    run_expiry("R8 masked expiry", 1'b0);
    chk("R8 irq count", 32'(irq_cnt - irq0), 32'd1);
    chk("R8 no rst", 32'(rst_cnt - rst0), 32'd0);

    // R6 sticky flag clear semantics
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R6 write one keeps", d, 32'h8000_0000);
    wr(A_STAT, 32'h7FFF_FFFF);
    rd(A_STAT, d); chk("R6 write zero clears", d, 32'h0);

    // R7 fully armed
    wr_msk(32'h0);
    chk("R7 mask readback", msk_rdata, 32'h0);
    chk("R7 rso readback", rso_rdata, 32'h0000_0100);
    rst0 = rst_cnt;
    wr(A_CTRL, EN);
    chk("R7 armed", {31'b0, armed}, 32'd1);
    run_expiry("R7 armed expiry", 1'b1);
    chk("R7 one rst pulse", 32'(rst_cnt - rst0), 32'd1);
    wr(A_STAT, 32'h0);

    // R7 reset-output enable cleared blocks the request
    wr_rso(32'h0);
    rst0 = rst_cnt;
    wr(A_CTRL, EN);
    chk("R7 armed needs rso", {31'b0, armed}, 32'd0);
    run_expiry("R7 rso off expiry", 1'b0);
    chk("R7 no rst without rso", 32'(rst_cnt - rst0), 32'd0);

    // R7 timer disabled drops armed
    wr_rso(32'h0000_0100);
    wr(A_CTRL, 32'h0);
    chk("R7 armed needs enable", {31'b0, armed}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule